// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel

This block is one channel of a bus-master DMA controller for an ATA-style disk interface. Software programs it through an 8-byte I/O register window that holds a command byte, a status byte and a 32-bit pointer to a table of 8-byte transfer descriptors. When software starts a device-to-memory transfer, the channel reads one descriptor from memory. It then copies the described number of bytes from a local sector buffer into memory, one byte per handshake beat, and finally reports completion in the status byte and on an interrupt line.

Only the low three address bits select a register, so two instances can sit 8 addresses apart, each decoding its own window. Pointer bytes can be reached with partial accesses of 1 to 4 bytes. Accesses that are malformed receive an error response and change nothing. Each channel tracks its position in the descriptor table. A start without a preceding rewind uses the next descriptor. Writing the command byte with start clear rewinds to the first descriptor.

Top module: `bmdma_channel`

## Requirements
- R1: After reset the command byte, status byte and table pointer read as zero, `irq` is low and `mem_valid` is low.
- R2: Only `reg_addr[2:0]` selects a register: offset 0 is the command byte, offset 2 the status byte, offsets 4 to 7 the pointer bytes with offset 4 the least significant. Offsets 1 and 3 give `reg_err` and read as zero.
- R3: A pointer access at offset 4+k of `reg_size` n bytes (access byte i on `reg_wdata`/`reg_rdata` bits 8i+7:8i) is served only when 1 <= n and k+n <= 4. Otherwise `reg_err` is set, the read data is zero and no byte changes.
- R4: The command and status bytes accept only `reg_size` 1. Any other size is answered with `reg_err`, and the register keeps its value.
- R5: Status bit 0 (active) is read-only. Bit 1 (error) and bit 2 (interrupt) clear when written with 1, and are left alone when written with 0. Bits 7:3 read zero.
- R6: Writing the command byte with bit 0 (start) clear rewinds the descriptor index to 0 and makes no memory access.
- R7: Writing the command byte with start set and bit 3 (to-memory) set while idle sets the active bit. It then reads two words from table pointer + 8 × index, and the index advances by one after the transfer completes.
- R8: Writing start set with bit 3 clear sets the error bit, leaves active clear and makes no memory access.
- R9: Descriptor word 0 is the memory base address. Bits 15:0 of word 1 are the byte count, where 0 means 65536. Buffer byte n is written to address base+n with a word-aligned `mem_addr`, one-hot `mem_be` and the byte copied to all four lanes.
- R10: A memory request stays valid with unchanged address, direction and data until `mem_ready` accepts it.
- R11: On completion, active clears and the interrupt bit sets. `irq` pulses for one cycle, but only if `irq_disable` is low.
- R12: A start written while a transfer is active is ignored: it causes no extra beats, no extra interrupt and no extra index advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe, one cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Register address; low 3 bits decoded |
| reg_size | input | 3 | Access width in bytes |
| reg_wdata | input | 32 | Write data, access byte i in lane i |
| reg_rdata | output | 32 | Read data, same cycle as the strobe |
| reg_err | output | 1 | Access rejected, same cycle as the strobe |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| buf_addr | output | BUF_AW | Sector buffer byte address |
| buf_data | input | 8 | Sector buffer byte, asynchronous read |
| irq_disable | input | 1 | Suppresses the interrupt pulse |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A wrong descriptor index shows up only at the next start, when the first descriptor read goes to an address other than pointer + 8 × index. The bench therefore chains starts with and without rewinds and checks which region of memory gets written. A wrong byte counter or buffer offset shows within one transfer: as a beat count that does not match, as wrong data, or as a sentinel byte next to the region being overwritten. A stuck active or interrupt flag is visible in the first status read after completion. A pointer byte corrupted by a rejected access is visible at the next 4-byte pointer read, which the sweep performs after every access.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  localparam int WORD_W    = 32;
  localparam int CNT_W     = 16;
  localparam int LEN_W     = CNT_W + 1;
  localparam int DESC_SH   = 3;   // descriptor size is 1 << DESC_SH bytes

  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd2;

  localparam int CMD_START = 0;
  localparam int CMD_TOMEM = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_BASE, ST_FETCH_LEN, ST_COPY, ST_FINISH
  } mover_state_t;

  function automatic logic [WORD_W-1:0] desc_addr(input logic [WORD_W-1:0] tbl,
                                                  input logic [WORD_W-1:0] idx);
    return tbl + (idx << DESC_SH);
  endfunction

  function automatic logic [LEN_W-1:0] xfer_len(input logic [CNT_W-1:0] cnt);
    return (cnt == '0) ? (LEN_W'(1) << CNT_W) : LEN_W'(cnt);
  endfunction

  function automatic logic ptr_span_ok(input logic [1:0] k, input logic [2:0] n);
    return (n != 3'd0) && ((4'(k) + 4'(n)) <= 4'd4);
  endfunction

  function automatic logic [3:0] ptr_byte_en(input logic [1:0] k, input logic [2:0] n);
    logic [7:0] t;
    t = (8'd1 << n) - 8'd1;
    t = t << k;
    return t[3:0];
  endfunction

  function automatic logic [WORD_W-1:0] read_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd3:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] lane_onehot(input logic [1:0] lsb);
    return 4'b0001 << lsb;
  endfunction

endpackage

// File: rtl/bmdma_window.sv
module bmdma_window
  import bmdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [2:0]  offset,
  input  logic [2:0]  size,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        err,
  input  logic        eng_busy,
  input  logic        eng_done,
  input  logic        irq_disable,
  output logic [31:0] tbl_ptr,
  output logic        launch,
  output logic        rewind,
  output logic        st_active,
  output logic        irq
);

  logic [7:0]  cmd_q;
  logic [31:0] ptr_q;
  logic        st_act_q, st_err_q, st_int_q, irq_q;

  logic [1:0]  k;
  logic        hit_cmd, hit_st, hit_ptr, acc_ok;
  logic        wr_cmd, wr_st, wr_ptr, start_req, unsupported;
  logic [3:0]  byte_wr;
  logic [31:0] wshift;

  always_comb begin
    k       = offset[1:0];
    hit_cmd = (offset == OFF_CMD);
    hit_st  = (offset == OFF_STAT);
    hit_ptr = offset[2];
    if (hit_cmd || hit_st) acc_ok = (size == 3'd1);
    else if (hit_ptr)      acc_ok = ptr_span_ok(k, size);
    else                   acc_ok = 1'b0;
    err         = req && !acc_ok;
    wr_cmd      = req && wr && acc_ok && hit_cmd;
    wr_st       = req && wr && acc_ok && hit_st;
    wr_ptr      = req && wr && acc_ok && hit_ptr;
    start_req   = wr_cmd && wdata[CMD_START];
    launch      = start_req && wdata[CMD_TOMEM] && !eng_busy;
    unsupported = start_req && !wdata[CMD_TOMEM] && !eng_busy;
    rewind      = wr_cmd && !wdata[CMD_START];
    byte_wr     = wr_ptr ? ptr_byte_en(k, size) : 4'b0000;
    wshift      = wdata << {k, 3'b000};
  end

  always_comb begin
    rdata = '0;
    if (req && acc_ok) begin
      if (hit_cmd)     rdata = {24'b0, cmd_q};
      else if (hit_st) rdata = {29'b0, st_int_q, st_err_q, st_act_q};
      else             rdata = (ptr_q >> {k, 3'b000}) & read_mask(size);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (wr_cmd) cmd_q <= wdata[7:0];
  end

  for (genvar b = 0; b < 4; b++) begin : g_ptr_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[8*b +: 8] <= '0;
      else if (byte_wr[b]) ptr_q[8*b +: 8] <= wshift[8*b +: 8];
    end
  end

  // Set events win over a write-one-to-clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_act_q <= 1'b0;
      st_err_q <= 1'b0;
      st_int_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (launch)        st_act_q <= 1'b1;
      else if (eng_done) st_act_q <= 1'b0;
      if (unsupported)                  st_err_q <= 1'b1;
      else if (wr_st && wdata[ST_ERR])  st_err_q <= 1'b0;
      if (eng_done)                     st_int_q <= 1'b1;
      else if (wr_st && wdata[ST_INT])  st_int_q <= 1'b0;
      irq_q <= eng_done && !irq_disable;
    end
  end

  assign tbl_ptr   = ptr_q;
  assign st_active = st_act_q;
  assign irq       = irq_q;

  a_r3_reject_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (req && err) |=> ($stable(ptr_q) && $stable(cmd_q)));

  a_r11_irq_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (st_int_q && !st_act_q));

  a_r11_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  a_r8_unsupported_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |=> (!st_act_q && st_err_q));

endmodule

// File: rtl/bmdma_mover.sv
module bmdma_mover
  import bmdma_pkg::*;
#(
  parameter int BUF_AW = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              rewind,
  input  logic [31:0]       tbl_ptr,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_data,
  output logic              busy,
  output logic              done
);

  mover_state_t        st_q;
  logic [31:0]         desc_q, base_q, cur_q;
  logic [LEN_W-1:0]    left_q;
  logic [BUF_AW-1:0]   off_q;
  logic [IDX_W-1:0]    idx_q;

  // Named internal events.
  logic base_hit, len_hit, copy_beat, last_beat;

  always_comb begin
    base_hit  = (st_q == ST_FETCH_BASE) && mem_ready;
    len_hit   = (st_q == ST_FETCH_LEN) && mem_ready;
    copy_beat = (st_q == ST_COPY) && mem_ready;
    last_beat = copy_beat && (left_q == LEN_W'(1));
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = '0;
    mem_wdata = '0;
    case (st_q)
      ST_FETCH_BASE: begin
        mem_valid = 1'b1;
        mem_addr  = desc_q;
      end
      ST_FETCH_LEN: begin
        mem_valid = 1'b1;
        mem_addr  = desc_q + 32'd4;
      end
      ST_COPY: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {cur_q[31:2], 2'b00};
        mem_be    = lane_onehot(cur_q[1:0]);
        mem_wdata = {4{buf_data}};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      desc_q <= '0;
      base_q <= '0;
      cur_q  <= '0;
      left_q <= '0;
      off_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) begin
          desc_q <= desc_addr(tbl_ptr, 32'(idx_q));
          st_q   <= ST_FETCH_BASE;
        end
        ST_FETCH_BASE: if (base_hit) begin
          base_q <= mem_rdata;
          st_q   <= ST_FETCH_LEN;
        end
        ST_FETCH_LEN: if (len_hit) begin
          left_q <= xfer_len(mem_rdata[CNT_W-1:0]);
          cur_q  <= base_q;
          off_q  <= '0;
          st_q   <= ST_COPY;
        end
        ST_COPY: if (copy_beat) begin
          cur_q  <= cur_q + 32'd1;
          off_q  <= off_q + BUF_AW'(1);
          left_q <= left_q - LEN_W'(1);
          if (last_beat) st_q <= ST_FINISH;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (rewind) idx_q <= '0;
    else if (st_q == ST_FINISH) idx_q <= idx_q + IDX_W'(1);
  end

  assign buf_addr = off_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FINISH);

  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_be)));

  a_r9_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> ($countones(mem_be) == 1));

  a_r9_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COPY) |-> (left_q != '0));

  a_r6_rewind_zeroes_index: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (idx_q == '0));

  a_r12_launch_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (st_q == ST_IDLE));

endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
  import bmdma_pkg::*;
#(
  parameter int REG_AW = 16,
  parameter int BUF_AW = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [2:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_data,
  input  logic              irq_disable,
  output logic              irq
);

  logic [31:0] tbl_ptr;
  logic        launch, rewind, st_active, eng_busy, eng_done;

  bmdma_window u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (reg_req),
    .wr          (reg_wr),
    .offset      (reg_addr[2:0]),
    .size        (reg_size),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .err         (reg_err),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .irq_disable (irq_disable),
    .tbl_ptr     (tbl_ptr),
    .launch      (launch),
    .rewind      (rewind),
    .st_active   (st_active),
    .irq         (irq)
  );

  bmdma_mover #(.BUF_AW(BUF_AW), .IDX_W(IDX_W)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .rewind    (rewind),
    .tbl_ptr   (tbl_ptr),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .buf_addr  (buf_addr),
    .buf_data  (buf_data),
    .busy      (eng_busy),
    .done      (eng_done)
  );

  a_r7_active_tracks_engine: assert property (@(posedge clk) disable iff (!rst_n)
    st_active == eng_busy);

endmodule

// File: tb/bmdma_channel_test.sv
`timescale 1ns/1ps
module bmdma_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [2:0]  reg_size = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [15:0] buf_addr;
  logic [7:0]  buf_data;
  logic        irq_disable = 1'b0;
  logic        irq;

  always #2 clk = ~clk;

  bmdma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .buf_addr(buf_addr), .buf_data(buf_data), .irq_disable(irq_disable), .irq(irq)
  );

  function automatic logic [7:0] bufb(input logic [15:0] n);
    return n[7:0] ^ n[15:8] ^ 8'h3C;
  endfunction
  assign buf_data = bufb(buf_addr);

  logic [7:0] mem [logic [31:0]];
  int checks = 0, errors = 0, wbeats = 0, rbeats = 0, irq_cnt = 0, cyc = 0;
  logic       stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA7;

  function automatic logic [7:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {peek(a + 3), peek(a + 2), peek(a + 1), peek(a)};
  endfunction
  task automatic poke32(input logic [31:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + 32'(i)] = v[8*i +: 8];
  endtask

  // Memory model: decides ready for the coming edge and commits that beat.
  always @(negedge clk) begin
    logic rdy;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy  = !stall_en || lfsr[0] || lfsr[1];
    if (rst_n && mem_valid && rdy) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[mem_addr + 32'(l)] = mem_wdata[8*l +: 8];
        wbeats++;
      end else rbeats++;
    end
    mem_rdata = rd32(mem_addr);
    mem_ready = rdy;
    if (irq) irq_cnt++;
  end

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      checks++; errors++;
      $display("FAIL R7 watchdog actual=%0d expected<%0d", cyc, 190000);
      summary_and_end();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [15:0] a, input logic [2:0] n,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = wr; reg_addr = a; reg_size = n; reg_wdata = wd;
    #1;
    rd = reg_rdata; er = reg_err;
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  logic [31:0] rd;
  logic        er;
  logic [31:0] ptr_model = '0;

  task automatic wait_idle();
    for (int i = 0; i < 80000; i++) begin
      acc(1'b0, 16'h0002, 3'd1, 32'h0, rd, er);
      if (rd[0] == 1'b0) break;
    end
  endtask

  task automatic xfer(input string tag, input logic [31:0] base, input int cnt,
                      input int exp_irq);
    int wb0, rb0, ic0, bad;
    mem[base - 1] = 8'hEE;
    mem[base + 32'(cnt)] = 8'hEE;
    wb0 = wbeats; rb0 = rbeats; ic0 = irq_cnt;
    acc(1'b1, 16'h0000, 3'd1, 32'h09, rd, er);
    acc(1'b0, 16'h0002, 3'd1, 32'h0, rd, er);
    chk({tag, " R7 active during transfer"}, 32'(rd[0]), 32'h1);
    wait_idle();
    repeat (3) @(negedge clk);
    acc(1'b0, 16'h0002, 3'd1, 32'h0, rd, er);
    chk({tag, " R11 status after completion"}, rd, 32'h04);
    chk({tag, " R9 write beats"}, 32'(wbeats - wb0), 32'(cnt));
    chk({tag, " R7 descriptor reads"}, 32'(rbeats - rb0), 32'd2);
    chk({tag, " R11 irq pulses"}, 32'(irq_cnt - ic0), 32'(exp_irq));
    bad = 0;
    for (int n = 0; n < cnt; n++)
      if (peek(base + 32'(n)) !== bufb(16'(n))) bad++;
    chk({tag, " R9 region data mismatches"}, 32'(bad), 32'h0);
    chk({tag, " R9 sentinels"}, {peek(base - 1), peek(base + 32'(cnt))}, 32'h0000EEEE);
    acc(1'b1, 16'h0002, 3'd1, 32'h04, rd, er);
    acc(1'b0, 16'h0002, 3'd1, 32'h0, rd, er);
    chk({tag, " R5 interrupt bit cleared by one"}, rd, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 mem_valid", 32'(mem_valid), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    acc(1'b0, 16'h0000, 3'd1, 32'h0, rd, er); chk("R1 command", rd, 32'h0);
    acc(1'b0, 16'h0002, 3'd1, 32'h0, rd, er); chk("R1 status", rd, 32'h0);
    acc(1'b0, 16'h0004, 3'd4, 32'h0, rd, er); chk("R1 pointer", rd, 32'h0);

    // R3 sweep over every start byte and size
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 8; n++) begin
        logic [31:0] wd, msk;
        logic        ok;
        wd = 32'h9E37_79B9 * 32'(k * 8 + n + 1);
        ok = (n >= 1) && (k + n <= 4);
        acc(1'b1, 16'(4 + k), 3'(n), wd, rd, er);
        chk("R3 write error flag", 32'(er), 32'(!ok));
        if (ok)
          for (int i = 0; i < n; i++) ptr_model[8*(k+i) +: 8] = wd[8*i +: 8];
        acc(1'b0, 16'h0004, 3'd4, 32'h0, rd, er);
        chk("R3 pointer after access", rd, ptr_model);
        acc(1'b0, 16'(4 + k), 3'(n), 32'h0, rd, er);
        msk = (n >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * n)) - 32'd1);
        chk("R3 partial read", rd, ok ? ((ptr_model >> (8 * k)) & msk) : 32'h0);
        chk("R3 read error flag", 32'(er), 32'(!ok));
      end
    end

    // R2 decode: unmapped offsets, upper address bits ignored
    acc(1'b1, 16'h0001, 3'd1, 32'hFF, rd, er); chk("R2 offset 1 error", 32'(er), 32'h1);
    acc(1'b0, 16'h0003, 3'd1, 32'h0, rd, er);
    chk("R2 offset 3 error", 32'(er), 32'h1);
    chk("R2 offset 3 data", rd, 32'h0);
    acc(1'b1, 16'hABCC, 3'd4, 32'h0000_1000, rd, er);
    chk("R2 aliased pointer write accepted", 32'(er), 32'h0);
    acc(1'b0, 16'h0004, 3'd4, 32'h0, rd, er); chk("R2 aliased pointer value", rd, 32'h0000_1000);
    acc(1'b0, 16'h0000, 3'd1, 32'h0, rd, er); chk("R2 command untouched", rd, 32'h0);

    // R4 width rules on command and status
    acc(1'b1, 16'h0000, 3'd2, 32'h0909, rd, er); chk("R4 command wide error", 32'(er), 32'h1);
    acc(1'b1, 16'h0002, 3'd4, 32'h0, rd, er);    chk("R4 status wide error", 32'(er), 32'h1);
    acc(1'b0, 16'h0000, 3'd1, 32'h0, rd, er);    chk("R4 command unchanged", rd, 32'h0);
    chk("R4 no memory traffic", 32'(wbeats + rbeats), 32'h0);

    // Descriptors: table at 0x1000
    poke32(32'h1000, 32'h0000_2003); poke32(32'h1004, 32'h0000_000D);
    poke32(32'h1008, 32'h0000_3000); poke32(32'h100C, 32'h8000_0005);
    poke32(32'h1010, 32'h0000_5002); poke32(32'h1014, 32'h0000_0028);
    poke32(32'h1018, 32'h0010_0000); poke32(32'h101C, 32'h8000_0000);

    stall_en = 1'b1;
    xfer("idx0", 32'h2003, 13, 1);          // R7 R9 R10 R11
    xfer("idx1 no rewind", 32'h3000, 5, 1); // R7 index advance

    // R6 rewind: start clear, no traffic, then index 0 with a new descriptor
    poke32(32'h1000, 32'h0000_4001); poke32(32'h1004, 32'h0000_0007);
    begin
      int b0;
      b0 = wbeats + rbeats;
      acc(1'b1, 16'h0000, 3'd1, 32'h08, rd, er);
      repeat (4) @(negedge clk);
      chk("R6 start clear makes no access", 32'(wbeats + rbeats - b0), 32'h0);
      acc(1'b0, 16'h0002, 3'd1, 32'h0, rd, er); chk("R6 status idle", rd, 32'h0);
    end
    xfer("R6 rewound", 32'h4001, 7, 1);

    // R11 interrupt suppressed (index 1 again)
    irq_disable = 1'b1;
    xfer("R11 irq disabled", 32'h3000, 5, 0);
    irq_disable = 1'b0;

    // R8 wrong direction, then R5 error clear and read-only active
    begin
      int b0;
      b0 = wbeats + rbeats;
      acc(1'b1, 16'h0000, 3'd1, 32'h01, rd, er);
      repeat (4) @(negedge clk);
      acc(1'b0, 16'h0002, 3'd1, 32'h0, rd, er);
      chk("R8 error set active clear", rd, 32'h02);
      chk("R8 no memory access", 32'(wbeats + rbeats - b0), 32'h0);
      acc(1'b1, 16'h0002, 3'd1, 32'h01, rd, er);
      acc(1'b0, 16'h0002, 3'd1, 32'h0, rd, er);
      chk("R5 write zero to error keeps it, active read-only", rd, 32'h02);
      acc(1'b1, 16'h0002, 3'd1, 32'hFA, rd, er);
      acc(1'b0, 16'h0002, 3'd1, 32'h0, rd, er);
      chk("R5 error cleared by one", rd, 32'h0);
    end

    // R12 start while active is ignored (index 2, 40 bytes)
    begin
      int wb0, ic0, bad;
      wb0 = wbeats; ic0 = irq_cnt;
      acc(1'b1, 16'h0000, 3'd1, 32'h09, rd, er);
      acc(1'b1, 16'h0000, 3'd1, 32'h09, rd, er);
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R12 beats of one transfer", 32'(wbeats - wb0), 32'd40);
      chk("R12 one interrupt", 32'(irq_cnt - ic0), 32'h1);
      bad = 0;
      for (int n = 0; n < 40; n++) if (peek(32'h5002 + 32'(n)) !== bufb(16'(n))) bad++;
      chk("R12 data mismatches", 32'(bad), 32'h0);
      acc(1'b1, 16'h0002, 3'd1, 32'h04, rd, er);
    end

    // R9 count 0 means 65536; also proves R12 index advanced once (index 3)
    stall_en = 1'b0;
    xfer("R9 count zero", 32'h0010_0000, 65536, 1);

    summary_and_end();
  end

endmodule